// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table held in ordinary memory. The virtual address carries a 10-bit index into the top-level table (bits 31:22), a 10-bit index into a second-level table (bits 21:12) and a 12-bit byte offset (bits 11:0), so pages are 4 KB. Each top-level entry covers a 4 MB region. A walk therefore takes two dependent memory reads. The second read can only be addressed once the first has returned.

A request is offered on a valid/ready channel, together with the frame number of the top-level table. The walker issues its reads on a memory request channel that also uses valid/ready. It takes the read data from a response strobe that may arrive any number of cycles later. The result leaves on a valid/ready response channel. A cleared valid bit in either table entry ends the walk at once with a fault that names the level. Caching of translations and servicing of faults belong to the surrounding logic.

On every valid/ready channel, the sender holds valid and its payload unchanged until ready is seen high at a clock edge. The walker obeys this rule as sender on the memory request and response channels. It accepts a new request only when it is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, and mem_req_valid and resp_valid are 0.
- R2: req_ready is high only while no walk is in progress. From the cycle a request is accepted until its response is taken, req_ready stays 0 and no further request is taken.
- R3: The first read goes to address ptbr×4096 + 4×vaddr[31:22], so virtual address 0x00403004 reads top-level entry 1.
- R4: The walker holds mem_req_valid high and mem_req_addr stable until mem_req_ready is seen high. It has at most one read outstanding, waits for mem_rsp_valid after each accepted read, and issues exactly one read per level visited.
- R5: A table entry is a 32-bit word with the frame number in bits 31:12 and the valid bit in bit 0; bits 11:1 are ignored. If the top-level entry has bit 0 equal to 0, the walk ends after that single read, with resp_fault = 2'd1 and resp_paddr = 0.
- R6: The second read goes to address (top-level entry[31:12])×4096 + 4×vaddr[21:12]. For virtual address 0x00403004 this is entry 3 of the selected table.
- R7: If the second-level entry has bit 0 equal to 0, the response carries resp_fault = 2'd2 and resp_paddr = 0.
- R8: On success, resp_fault = 2'd0 and resp_paddr = {second-level entry[31:12], vaddr[11:0]}. The code 2'd3 is never produced.
- R9: While resp_valid is high and resp_ready is low, resp_valid, resp_paddr and resp_fault hold their values.
- R10: req_vaddr and ptbr are captured when the request is accepted. Changing them during the walk does not alter the read addresses or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and taking a request |
| req_vaddr | input | 32 | Virtual address to translate |
| ptbr | input | 20 | Frame number of the top-level table |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid, one cycle per read |
| mem_rsp_data | input | 32 | Table entry read from memory |
| resp_valid | output | 1 | Translation result valid |
| resp_ready | input | 1 | Consumer takes the result |
| resp_paddr | output | 32 | Physical address, zero on a fault |
| resp_fault | output | 2 | 0 success, 1 top-level fault, 2 second-level fault |

## Verification
The hardest case to reach from the ports is a walk whose result depends on timing and on a latched value at once. Such a walk combines a memory that stalls the request channel and delays its response by a varying number of cycles with inputs that are changed while the walk is in flight. The bench meets this case with a memory model that picks random acceptance and response delays, and with a request driver that overwrites req_vaddr and ptbr with unrelated values after every acceptance. The table contents are arithmetic functions of the two indices, so sweeping all 1024 top-level indices covers both fault levels and success, each one interleaved with stalls. The expected read addresses and results come from the same formulas.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_LVL1 = 2'd1,
    WS_LVL2 = 2'd2,
    WS_DONE = 2'd3
  } walk_state_t;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_TOP  = 2'd1;
  localparam logic [1:0] FLT_LEAF = 2'd2;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int FRAME_W = 20,
  parameter int IDX_W   = 10,
  parameter int OFF_W   = 12,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [IDX_W-1:0]   index_i,
  output logic [PA_W-1:0]    addr_o
);

  logic [PA_W-1:0] table_base;
  logic [PA_W-1:0] entry_ofs;

  // each entry is one 4-byte word inside a page-sized table
  assign table_base = {frame_i, {OFF_W{1'b0}}};
  assign entry_ofs  = {{(PA_W-IDX_W){1'b0}}, index_i} << 2;
  assign addr_o     = table_base + entry_ofs;

endmodule

// File: rtl/pt_pte_decode.sv
module pt_pte_decode #(
  parameter int PTE_W = 32,
  parameter int OFF_W = 12,
  localparam int FRAME_W = PTE_W - OFF_W
) (
  input  logic [PTE_W-1:0]   pte_i,
  output logic               present_o,
  output logic [FRAME_W-1:0] frame_o
);

  logic unused_flags;

  assign present_o    = pte_i[0];
  assign frame_o      = pte_i[PTE_W-1:OFF_W];
  assign unused_flags = ^pte_i[OFF_W-1:1];

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        pte_present,
  input  logic        resp_ready,
  output walk_state_t state_o,
  output logic        req_ready,
  output logic        mem_req_valid,
  output logic        rsp_take,
  output logic        resp_valid,
  output logic [1:0]  fault_code
);

  walk_state_t state_q;
  logic        issued_q;
  logic        reading;

  assign reading       = (state_q == WS_LVL1) || (state_q == WS_LVL2);
  assign req_ready     = (state_q == WS_IDLE);
  assign mem_req_valid = reading && !issued_q;
  assign rsp_take      = reading && issued_q && mem_rsp_valid;
  assign resp_valid    = (state_q == WS_DONE);
  assign state_o       = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= WS_IDLE;
      issued_q   <= 1'b0;
      fault_code <= FLT_NONE;
    end else begin
      case (state_q)
        WS_IDLE: begin
          if (req_valid) begin
            state_q    <= WS_LVL1;
            issued_q   <= 1'b0;
            fault_code <= FLT_NONE;
          end
        end
        WS_LVL1, WS_LVL2: begin
          if (mem_req_valid && mem_req_ready) begin
            issued_q <= 1'b1;
          end
          if (rsp_take) begin
            issued_q <= 1'b0;
            if (!pte_present) begin
              fault_code <= (state_q == WS_LVL1) ? FLT_TOP : FLT_LEAF;
              state_q    <= WS_DONE;
            end else if (state_q == WS_LVL1) begin
              state_q <= WS_LVL2;
            end else begin
              state_q <= WS_DONE;
            end
          end
        end
        WS_DONE: begin
          if (resp_ready) begin
            state_q <= WS_IDLE;
          end
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int PTE_W = 32,
  localparam int FRAME_W = PTE_W - OFF_W,
  localparam int VA_W    = 2 * IDX_W + OFF_W,
  localparam int PA_W    = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [FRAME_W-1:0] ptbr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_data,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic [PA_W-1:0]    resp_paddr,
  output logic [1:0]         resp_fault
);

  localparam int NUM_LVL = 2;

  walk_state_t        state;
  logic               rsp_take;
  logic               pte_present;
  logic [FRAME_W-1:0] pte_frame;

  logic [VA_W-1:0]    va_q;
  logic [FRAME_W-1:0] base_q;
  logic [FRAME_W-1:0] tbl_q;
  logic [PA_W-1:0]    paddr_q;

  logic [FRAME_W-1:0] lvl_frame [NUM_LVL];
  logic [IDX_W-1:0]   lvl_idx   [NUM_LVL];
  logic [PA_W-1:0]    lvl_addr  [NUM_LVL];

  pt_walk_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .pte_present   (pte_present),
    .resp_ready    (resp_ready),
    .state_o       (state),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .rsp_take      (rsp_take),
    .resp_valid    (resp_valid),
    .fault_code    (resp_fault)
  );

  pt_pte_decode #(.PTE_W(PTE_W), .OFF_W(OFF_W)) u_decode (
    .pte_i     (mem_rsp_data),
    .present_o (pte_present),
    .frame_o   (pte_frame)
  );

  assign lvl_frame[0] = base_q;
  assign lvl_frame[1] = tbl_q;

  // level 0 uses the upper index field, level 1 the lower one
  for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
    assign lvl_idx[lv] = va_q[OFF_W + IDX_W*(NUM_LVL-1-lv) +: IDX_W];
    pt_entry_addr #(.FRAME_W(FRAME_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
      .frame_i (lvl_frame[lv]),
      .index_i (lvl_idx[lv]),
      .addr_o  (lvl_addr[lv])
    );
  end

  assign mem_req_addr = (state == WS_LVL2) ? lvl_addr[1] : lvl_addr[0];
  assign resp_paddr   = paddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q    <= '0;
      base_q  <= '0;
      tbl_q   <= '0;
      paddr_q <= '0;
    end else begin
      if (req_valid && req_ready) begin
        va_q    <= req_vaddr;
        base_q  <= ptbr;
        paddr_q <= '0;
      end
      if (rsp_take && pte_present) begin
        if (state == WS_LVL1) begin
          tbl_q <= pte_frame;
        end else begin
          paddr_q <= {pte_frame, va_q[OFF_W-1:0]};
        end
      end
    end
  end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            resp_valid,
  input logic            resp_ready,
  input logic [PA_W-1:0] resp_paddr,
  input logic [1:0]      resp_fault
);

  logic [1:0] outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 2'd0;
    end else begin
      outstanding <= outstanding + 2'(mem_req_valid && mem_req_ready) - 2'(mem_rsp_valid);
    end
  end

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R4
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (outstanding == 2'd0));

  // R2
  idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !resp_valid));

  // R9
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=>
      (resp_valid && $stable(resp_paddr) && $stable(resp_fault)));

  // R7
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault != 2'd0) |-> (resp_paddr == '0));

  // R8
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_fault != 2'd3));

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .resp_valid    (resp_valid),
  .resp_ready    (resp_ready),
  .resp_paddr    (resp_paddr),
  .resp_fault    (resp_fault)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

  localparam logic [19:0] BASE = 20'h00010;
  localparam logic [19:0] L2F  = 20'h20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [19:0] ptbr = BASE;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        resp_valid;
  logic        resp_ready = 1'b0;
  logic [31:0] resp_paddr;
  logic [1:0]  resp_fault;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int rd_cnt = 0;
  logic [31:0] rd_addr [4];

  pt_walker dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .ptbr          (ptbr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .resp_valid    (resp_valid),
    .resp_ready    (resp_ready),
    .resp_paddr    (resp_paddr),
    .resp_fault    (resp_fault)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", 32'(cyc), 32'd150000);
      finish_run();
    end
  end

  // table contents as arithmetic functions of the indices
  function automatic bit top_ok(input int i);
    return (i % 3) != 2;
  endfunction
  function automatic bit leaf_ok(input int i, input int j);
    return ((i + j) % 5) != 3;
  endfunction
  function automatic logic [19:0] leaf_frame(input int i, input int j);
    return 20'((i * 37 + j * 11 + 5) & 32'hFFFFF);
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    int i;
    int j;
    if (a[31:12] == BASE) begin
      i = int'(a[11:2]);
      return {L2F + 20'(i), 12'h5A4 | 12'(top_ok(i))};
    end else if (a[31:12] >= L2F && a[31:12] < L2F + 20'd1024) begin
      i = int'(a[31:12] - L2F);
      j = int'(a[11:2]);
      return {leaf_frame(i, j), 12'h2B6 | 12'(leaf_ok(i, j))};
    end
    return 32'h0;
  endfunction

  // memory model: random request stalls and response delays
  initial begin
    bit pend;
    int dly;
    logic [31:0] pend_addr;
    pend = 0;
    dly = 0;
    pend_addr = '0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (!rst_n) begin
        pend = 0;
        mem_req_ready = 1'b0;
      end else begin
        if (pend) begin
          if (dly == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data = mem_word(pend_addr);
            pend = 0;
          end else begin
            dly--;
          end
        end
        mem_req_ready = !pend && ($urandom_range(3) != 0);
        #1;
        if (mem_req_valid && mem_req_ready) begin
          pend = 1;
          pend_addr = mem_req_addr;
          dly = $urandom_range(3);
          if (rd_cnt < 4) rd_addr[rd_cnt] = mem_req_addr;
          rd_cnt++;
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va);
    int i;
    int j;
    int n;
    bit acc;
    bit busy_ready;
    bit seen;
    logic [31:0] first_pa;
    logic [1:0] first_fl;
    logic [31:0] exp_pa;
    logic [1:0] exp_fl;
    int exp_rd;
    i = int'(va[31:22]);
    j = int'(va[21:12]);
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    ptbr = BASE;
    n = 0;
    forever begin
      acc = req_ready;
      @(posedge clk);
      if (acc) break;
      n++;
      if (n > 50) begin
        check(1'b0, "R2 accept", 32'(n), 32'd0);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    // R10: disturb the captured inputs during the walk
    req_vaddr = ~va;
    ptbr = 20'hABCDE;
    busy_ready = 0;
    seen = 0;
    first_pa = '0;
    first_fl = '0;
    n = 0;
    forever begin
      resp_ready = ($urandom_range(2) == 0);
      if (req_ready) busy_ready = 1;
      if (resp_valid && !seen) begin
        seen = 1;
        first_pa = resp_paddr;
        first_fl = resp_fault;
      end
      if (resp_valid && resp_ready) break;
      n++;
      if (n > 200) begin
        check(1'b0, "R4 response timeout", 32'(n), 32'd0);
        break;
      end
      @(negedge clk);
    end
    if (!top_ok(i)) begin
      exp_fl = 2'd1; exp_pa = '0; exp_rd = 1;
    end else if (!leaf_ok(i, j)) begin
      exp_fl = 2'd2; exp_pa = '0; exp_rd = 2;
    end else begin
      exp_fl = 2'd0; exp_pa = {leaf_frame(i, j), va[11:0]}; exp_rd = 2;
    end
    check(!busy_ready, "R2 req_ready during walk", 32'(busy_ready), 32'd0);
    check(resp_fault == exp_fl, exp_fl == 2'd1 ? "R5 fault code" : (exp_fl == 2'd2 ? "R7 fault code" : "R8 fault code"),
          32'(resp_fault), 32'(exp_fl));
    check(resp_paddr == exp_pa, exp_fl == 2'd0 ? "R8 paddr" : "R7 paddr on fault", resp_paddr, exp_pa);
    check(first_pa == resp_paddr && first_fl == resp_fault, "R9 held result", first_pa, resp_paddr);
    check(rd_cnt == exp_rd, exp_fl == 2'd1 ? "R5 read count" : "R4 read count", 32'(rd_cnt), 32'(exp_rd));
    check(rd_addr[0] == {BASE, 12'h0} + 32'(i * 4), "R3 R10 first read addr", rd_addr[0], {BASE, 12'h0} + 32'(i * 4));
    if (exp_rd == 2 && rd_cnt >= 2)
      check(rd_addr[1] == {L2F + 20'(i), 12'h0} + 32'(j * 4), "R6 second read addr",
            rd_addr[1], {L2F + 20'(i), 12'h0} + 32'(j * 4));
    @(posedge clk);
    @(negedge clk);
    resp_ready = 1'b0;
    ptbr = BASE;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
    check(resp_valid == 1'b0, "R1 resp_valid", 32'(resp_valid), 32'd0);

    // R3 R6 R8: the worked example decodes as indices 1 and 3, offset 4
    walk(32'h00403004);
    check(rd_addr[0] == 32'h00010004, "R3 example L1 addr", rd_addr[0], 32'h00010004);
    check(rd_addr[1] == 32'h2000100C, "R6 example L2 addr", rd_addr[1], 32'h2000100C);

    // sweep every top-level index (covers both fault levels and success)
    for (int i = 0; i < 1024; i++) begin
      walk({10'(i), 10'((i * 7 + 3) % 1024), 12'((i * 13) % 4096)});
    end
    // sweep every second-level index under one valid top-level entry
    for (int j = 0; j < 1024; j++) begin
      walk({10'd4, 10'(j), 12'hFFF - 12'(j)});
    end
    finish_run();
  end

endmodule